// File: doc/BRIEF.md
# SDRAM Burst Column Address Generator

This block produces the column address sequence that a synchronous DRAM walks through during one read or write burst. A read or write command loads a 9-bit start column and the burst settings in force at that moment. The settings are a 3-bit length code, a burst-order bit and a bit that turns every write into a single beat. From the next enabled clock onward the block presents one column per enabled clock, and it raises a flag on the final beat of a fixed-length burst.

A burst can end early on any enabled clock. A burst-stop or a precharge command ends it. A fresh read or write command on any cycle abandons the current sequence and starts a new one from its own start column. While the clock enable is low, the internal state is frozen and the burst is stretched. Commands presented during that time are not taken.

Top module: `burst_col_gen`

## Requirements
- R1: After reset, `col_valid` and `last_beat` are 0.
- R2: Length codes on `blen_code`: 3'b000 gives 1 beat, 3'b001 gives 2, 3'b010 gives 4, 3'b011 gives 8. The first column equals `start_col` and appears in the cycle after the command edge. `col_valid` stays 1 for exactly that many enabled clocks.
- R3: With `ilv_order`=0 (sequential), beat i carries the start column with its low log2(L) bits replaced by (low bits + i) mod L. The upper bits are kept.
- R4: With `ilv_order`=1 (interleaved), beat i carries the start column with its low log2(L) bits XORed with i.
- R5: `last_beat` is 1 only on the final beat of a fixed-length burst. On the next enabled clock `col_valid` drops to 0, unless a new command arrives.
- R6: Code 3'b111 with sequential order gives a full-page burst. It counts up by one per beat, wraps from 511 to 0, never raises `last_beat`, and runs until it is terminated.
- R7: Codes 3'b100, 3'b101 and 3'b110, and code 3'b111 with interleaved order, give a single-beat burst.
- R8: With `single_wr`=1, a write command (`cmd_wr`) gives a single beat. A read command (`cmd_rd`) keeps the programmed length.
- R9: A `cmd_stop` or `cmd_pre` on an enabled clock ends the burst, so `col_valid` is 0 in the following cycle.
- R10: A read or write command on any enabled clock, including one in the middle of a burst, restarts the sequence at its own start column with its own settings.
- R11: While `cke` is 0, `col_out`, `col_valid` and `last_beat` hold their values, and commands are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cke | input | 1 | Clock enable; low freezes the burst |
| cmd_rd | input | 1 | Read command strobe |
| cmd_wr | input | 1 | Write command strobe |
| cmd_stop | input | 1 | Burst-stop command strobe |
| cmd_pre | input | 1 | Precharge command strobe |
| start_col | input | 9 | Start column of the new burst |
| blen_code | input | 3 | Burst length code |
| ilv_order | input | 1 | 0 = sequential order, 1 = interleaved order |
| single_wr | input | 1 | 1 = writes are single beat |
| col_out | output | 9 | Current column address |
| col_valid | output | 1 | Column output is a live beat |
| last_beat | output | 1 | Final beat of a fixed-length burst |

## Verification
The assertions check, on every clock, the behaviours that follow from port values alone:
- A frozen clock enable holds every output.
- A termination strobe empties the next cycle.
- A command loads its start column.
- A final beat is followed by an idle cycle.
- A single-beat write is flagged as last.

The column orders cannot be checked from a single cycle, because they depend on settings captured at the command. The bench scenarios show them: the wrap within an aligned block, the XOR pattern of interleaved order, the full-page roll from 511 to 0, the reserved codes, and a restart in mid-burst.

// File: rtl/burst_col_gen.sv
module burst_col_gen #(
  parameter int COL_W = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cke,
  input  logic             cmd_rd,
  input  logic             cmd_wr,
  input  logic             cmd_stop,
  input  logic             cmd_pre,
  input  logic [COL_W-1:0] start_col,
  input  logic [2:0]       blen_code,
  input  logic             ilv_order,
  input  logic             single_wr,
  output logic [COL_W-1:0] col_out,
  output logic             col_valid,
  output logic             last_beat
);

  localparam logic [COL_W-1:0] PAGE_MASK = {COL_W{1'b1}};

  logic             busy;
  logic             full_pg;
  logic             ilv_q;
  logic [COL_W-1:0] base_q;
  logic [COL_W-1:0] idx_q;
  logic [COL_W-1:0] mask_q;

  logic [COL_W-1:0] mask_d;
  logic             full_d;
  logic             new_cmd;

  assign new_cmd = cmd_rd | cmd_wr;

  always_comb begin
    mask_d = '0;
    full_d = 1'b0;
    if (!(cmd_wr && single_wr)) begin
      case (blen_code)
        3'b001:  mask_d = COL_W'(1);
        3'b010:  mask_d = COL_W'(3);
        3'b011:  mask_d = COL_W'(7);
        3'b111:  if (!ilv_order) begin
                   mask_d = PAGE_MASK;
                   full_d = 1'b1;
                 end
        default: mask_d = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      full_pg <= 1'b0;
      ilv_q   <= 1'b0;
      base_q  <= '0;
      idx_q   <= '0;
      mask_q  <= '0;
    end else if (cke) begin
      if (new_cmd) begin
        busy    <= 1'b1;
        full_pg <= full_d;
        ilv_q   <= ilv_order;
        base_q  <= start_col;
        idx_q   <= '0;
        mask_q  <= mask_d;
      end else if (cmd_stop || cmd_pre) begin
        busy <= 1'b0;
      end else if (busy) begin
        if (last_beat) busy <= 1'b0;
        else           idx_q <= idx_q + 1'b1;
      end
    end
  end

  assign col_out   = ilv_q ? (base_q ^ (idx_q & mask_q))
                           : ((base_q & ~mask_q) | ((base_q + idx_q) & mask_q));
  assign col_valid = busy;
  assign last_beat = busy & ~full_pg & (idx_q == mask_q);

endmodule

module burst_col_gen_chk #(
  parameter int COL_W = 9
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cke,
  input logic             cmd_rd,
  input logic             cmd_wr,
  input logic             cmd_stop,
  input logic             cmd_pre,
  input logic             single_wr,
  input logic [COL_W-1:0] start_col,
  input logic [COL_W-1:0] col_out,
  input logic             col_valid,
  input logic             last_beat
);

  a_r11_freeze: assert property (@(posedge clk) disable iff (!rst_n)
    !cke |=> $stable(col_out) && $stable(col_valid) && $stable(last_beat));

  a_r9_terminate: assert property (@(posedge clk) disable iff (!rst_n)
    cke && (cmd_stop || cmd_pre) && !cmd_rd && !cmd_wr |=> !col_valid);

  a_r10_restart: assert property (@(posedge clk) disable iff (!rst_n)
    cke && (cmd_rd || cmd_wr) |=> col_valid && (col_out == $past(start_col)));

  a_r5_last_ends: assert property (@(posedge clk) disable iff (!rst_n)
    cke && last_beat && !cmd_rd && !cmd_wr |=> !col_valid);

  a_r5_last_in_burst: assert property (@(posedge clk) disable iff (!rst_n)
    last_beat |-> col_valid);

  a_r8_single_write: assert property (@(posedge clk) disable iff (!rst_n)
    cke && cmd_wr && !cmd_rd && single_wr |=> last_beat);

endmodule

bind burst_col_gen burst_col_gen_chk #(.COL_W(COL_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cke(cke), .cmd_rd(cmd_rd), .cmd_wr(cmd_wr),
  .cmd_stop(cmd_stop), .cmd_pre(cmd_pre), .single_wr(single_wr),
  .start_col(start_col), .col_out(col_out), .col_valid(col_valid),
  .last_beat(last_beat)
);

// File: tb/burst_col_gen_tb.sv
module burst_col_gen_tb;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cke = 1'b1;
  logic       cmd_rd = 1'b0, cmd_wr = 1'b0, cmd_stop = 1'b0, cmd_pre = 1'b0;
  logic [8:0] start_col = '0;
  logic [2:0] blen_code = '0;
  logic       ilv_order = 1'b0, single_wr = 1'b0;
  logic [8:0] col_out;
  logic       col_valid, last_beat;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #10 clk = ~clk;

  burst_col_gen u_dut (.*);

  typedef struct packed {
    logic       wr;
    logic [2:0] code;
    logic       ilv;
    logic       sw;
    logic [8:0] start;
    logic [3:0] len;
    logic [71:0] cols;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t VEC [NV] = '{
    '{1'b0, 3'b011, 1'b0, 1'b0, 9'd13,  4'd8,
      {9'd12, 9'd11, 9'd10, 9'd9, 9'd8, 9'd15, 9'd14, 9'd13}},
    '{1'b0, 3'b011, 1'b1, 1'b0, 9'd13,  4'd8,
      {9'd10, 9'd11, 9'd8, 9'd9, 9'd14, 9'd15, 9'd12, 9'd13}},
    '{1'b0, 3'b010, 1'b0, 1'b0, 9'd7,   4'd4,
      {36'd0, 9'd6, 9'd5, 9'd4, 9'd7}},
    '{1'b0, 3'b010, 1'b1, 1'b0, 9'd7,   4'd4,
      {36'd0, 9'd4, 9'd5, 9'd6, 9'd7}},
    '{1'b1, 3'b001, 1'b0, 1'b0, 9'd511, 4'd2,
      {54'd0, 9'd510, 9'd511}},
    '{1'b1, 3'b010, 1'b0, 1'b1, 9'd20,  4'd1,
      {63'd0, 9'd20}},
    '{1'b0, 3'b010, 1'b0, 1'b1, 9'd20,  4'd4,
      {36'd0, 9'd23, 9'd22, 9'd21, 9'd20}},
    '{1'b0, 3'b101, 1'b0, 1'b0, 9'd33,  4'd1,
      {63'd0, 9'd33}},
    '{1'b0, 3'b111, 1'b1, 1'b0, 9'd40,  4'd1,
      {63'd0, 9'd40}},
    '{1'b1, 3'b000, 1'b0, 1'b0, 9'd100, 4'd1,
      {63'd0, 9'd100}}
  };

  task automatic chk(input string req, input int got, input int exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d", req, got, exp);
    end
  endtask

  task automatic issue(input logic wr, input logic [2:0] code, input logic ilv,
                       input logic sw, input logic [8:0] st);
    @(negedge clk);
    cmd_rd = ~wr; cmd_wr = wr; blen_code = code; ilv_order = ilv;
    single_wr = sw; start_col = st;
    @(negedge clk);
    cmd_rd = 0; cmd_wr = 0;
  endtask

  initial begin
    repeat (2000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: got 1 expected 0");
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 valid", col_valid, 0);
    chk("R1 last", last_beat, 0);
    rst_n = 1'b1;

    // R2 R3 R4 R5 R7 R8 table
    for (int v = 0; v < NV; v++) begin
      issue(VEC[v].wr, VEC[v].code, VEC[v].ilv, VEC[v].sw, VEC[v].start);
      for (int b = 0; b < int'(VEC[v].len); b++) begin
        if (b > 0) @(negedge clk);
        chk("R2 valid", col_valid, 1);
        chk("R3/R4 col", col_out, VEC[v].cols[b*9 +: 9]);
        chk("R5 last", last_beat, (b == int'(VEC[v].len) - 1) ? 1 : 0);
      end
      @(negedge clk);
      chk("R5 end", col_valid, 0);
    end

    // R6 full page wrap, then stop
    issue(1'b0, 3'b111, 1'b0, 1'b0, 9'd510);
    chk("R6 col", col_out, 510); chk("R6 last", last_beat, 0);
    @(negedge clk); chk("R6 col", col_out, 511);
    @(negedge clk); chk("R6 wrap", col_out, 0); chk("R6 last", last_beat, 0);
    @(negedge clk); chk("R6 col", col_out, 1); chk("R6 valid", col_valid, 1);
    cmd_stop = 1; @(negedge clk); cmd_stop = 0;
    chk("R9 stop", col_valid, 0);

    // R9 precharge mid burst
    issue(1'b0, 3'b011, 1'b0, 1'b0, 9'd64);
    @(negedge clk); chk("R9 col", col_out, 65);
    cmd_pre = 1; @(negedge clk); cmd_pre = 0;
    chk("R9 pre", col_valid, 0);

    // R10 restart mid burst
    issue(1'b0, 3'b011, 1'b0, 1'b0, 9'd0);
    @(negedge clk); chk("R10 col", col_out, 1);
    issue(1'b1, 3'b010, 1'b1, 1'b0, 9'd101);
    chk("R10 restart", col_out, 101);
    @(negedge clk); chk("R10 ilv", col_out, 100);
    @(negedge clk); chk("R10 ilv", col_out, 103);
    @(negedge clk); chk("R10 ilv", col_out, 102); chk("R10 last", last_beat, 1);
    @(negedge clk); chk("R10 end", col_valid, 0);

    // R11 freeze, commands ignored while cke low
    issue(1'b0, 3'b001, 1'b0, 1'b0, 9'd200);
    cke = 0; cmd_stop = 1;
    @(negedge clk); chk("R11 hold", col_out, 200); chk("R11 valid", col_valid, 1);
    cmd_stop = 0; cmd_rd = 1; start_col = 9'd300;
    @(negedge clk); chk("R11 hold", col_out, 200); chk("R11 last", last_beat, 0);
    cmd_rd = 0; cke = 1;
    @(negedge clk); chk("R11 resume", col_out, 201); chk("R11 last", last_beat, 1);
    @(negedge clk); chk("R11 end", col_valid, 0);

    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule